// File: doc/BRIEF.md
# Processor Presence Map

This block keeps a 256-bit map of which processors are present and shows it to the host as a byte-addressed status window 32 bytes long. Processor `n` owns bit `n % 8` of byte `n / 8`. The map is loaded from a parameter mask at reset. After that, bits are only ever set, and only by plug requests. A plug request for an identifier that fits the window sets its bit and sends a one-cycle event pulse to the host.

The block starts in legacy mode. Legacy mode ends for good, until the next reset, in either of two cases:
- the host writes a zero byte at offset 0;
- a plug request arrives whose identifier lies beyond the window.

Once legacy mode has ended, the bus window reads as zero. Every plug request is then passed on unchanged through a forwarding output, for a newer register set outside this block to handle.

The host bus accepts accesses of 1 to 4 bytes. Each access is treated as a little-endian run of single-byte accesses starting at the given offset. A read result appears one cycle after the request.

Top module: `cpu_presence_map`

## Requirements
- R1: After reset, `legacy_mode` is 1, `gpe_pulse` and `fwd_valid` are 0, and the map equals the `INIT_MASK` parameter. Bit `8*b+i` of the mask is bit `i` of byte `b`.
- R2: A read with `rd_en` high returns its data one cycle later, with `rd_valid` high for that one cycle. Lane `k` (`rd_data[8k+7:8k]`) holds map byte `addr+k` when `k <= size` and `addr+k < 32`; otherwise the lane is 0. The `size` field holds the access length minus one.
- R3: In legacy mode, a plug request with `plug_id < 256` sets bit `plug_id % 8` of byte `plug_id / 8` and leaves every other bit unchanged. `gpe_pulse` is high for exactly the one cycle that follows the request. This holds even when the bit was already set.
- R4: Bus writes never change map contents.
- R5: A write at `addr == 0` whose lane-0 byte `wr_data[7:0]` is zero clears `legacy_mode` from the next cycle on. Writes at other offsets, and writes with a nonzero lane-0 byte, leave the mode unchanged. This holds even if higher lanes are zero.
- R6: In legacy mode, a plug request with `plug_id >= 256` does three things: it clears `legacy_mode`, it raises `fwd_valid` for one cycle with `fwd_id` equal to the request identifier, and it raises no `gpe_pulse`.
- R7: With `legacy_mode` at 0, every read returns zero data. Every plug request gives a one-cycle `fwd_valid` carrying its identifier and no `gpe_pulse`.
- R8: Once cleared, `legacy_mode` stays 0 until reset, whatever writes or plug requests follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | 5 | Byte offset of lane 0 |
| size | input | 2 | Access length minus one |
| wr_data | input | 32 | Write data, lane 0 in the low byte |
| rd_data | output | 32 | Read data, lane 0 in the low byte |
| rd_valid | output | 1 | Read data valid |
| plug_valid | input | 1 | Plug request strobe |
| plug_id | input | 10 | Processor identifier of the request |
| gpe_pulse | output | 1 | One-cycle event to the host on a legacy plug |
| fwd_valid | output | 1 | One-cycle forwarded plug request |
| fwd_id | output | 10 | Identifier of the forwarded request |
| legacy_mode | output | 1 | 1 while the legacy window is active |

## Verification
Plug requests are tried with four kinds of identifier:
- new identifiers, which show that the right byte and bit are set;
- identifiers whose bit was preloaded, which show that the event fires even when the map does not change;
- the highest in-window identifier, 255, which checks the last byte;
- identifiers of 256 and above, which check the mode switch and the forwarding.

Reads are tried with all four lengths and at the window edge, so that lanes beyond the length and lanes beyond offset 31 are told apart from real zero bytes. Writes use three patterns:
- nonzero data at offset 0;
- zero data at another offset;
- zero high lanes with a nonzero low lane.

Each of these must leave the mode alone. A true lane-0 zero at offset 0 must switch it.

// File: rtl/cpm_pkg.sv
`timescale 1ns/1ps
package cpm_pkg;
   typedef enum logic [1:0] {
      PLUG_IDLE = 2'd0,
      PLUG_SET  = 2'd1,
      PLUG_FWD  = 2'd2
   } plug_route_e;
endpackage

// File: rtl/cpm_mode_ctl.sv
`timescale 1ns/1ps
module cpm_mode_ctl
   import cpm_pkg::*;
#(
   parameter int PLUG_ID_W = 10,
   parameter int IDX_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 plug_valid,
   input  logic [PLUG_ID_W-1:0] plug_id,
   input  logic                 switch_req,
   output logic                 legacy_mode,
   output plug_route_e          route,
   output logic                 gpe_pulse,
   output logic                 fwd_valid,
   output logic [PLUG_ID_W-1:0] fwd_id
);
   logic in_window;

   generate
      if (PLUG_ID_W > IDX_W) begin : g_wide_id
         assign in_window = (plug_id[PLUG_ID_W-1:IDX_W] == '0);
      end else begin : g_exact_id
         assign in_window = 1'b1;
      end
   endgenerate

   always_comb begin
      if (!plug_valid)                   route = PLUG_IDLE;
      else if (legacy_mode && in_window) route = PLUG_SET;
      else                               route = PLUG_FWD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         legacy_mode <= 1'b1;
         gpe_pulse   <= 1'b0;
         fwd_valid   <= 1'b0;
         fwd_id      <= '0;
      end else begin
         gpe_pulse <= (route == PLUG_SET);
         fwd_valid <= (route == PLUG_FWD);
         if (route == PLUG_FWD) fwd_id <= plug_id;
         if (switch_req || (plug_valid && !in_window)) legacy_mode <= 1'b0;
      end
   end
endmodule

// File: rtl/cpm_bitmap.sv
`timescale 1ns/1ps
module cpm_bitmap #(
   parameter int                       MAP_BYTES = 32,
   parameter logic [MAP_BYTES*8-1:0]   INIT_MASK = '0,
   localparam int                      IDX_W     = $clog2(MAP_BYTES*8),
   localparam int                      ADDR_W    = IDX_W - 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic [IDX_W-1:0]       set_idx,
   output logic [MAP_BYTES*8-1:0] map_flat
);
   logic [ADDR_W-1:0] set_byte;
   logic [2:0]        set_bit;

   assign set_byte = set_idx[IDX_W-1:3];
   assign set_bit  = set_idx[2:0];

   for (genvar b = 0; b < MAP_BYTES; b++) begin : g_byte
      localparam logic [ADDR_W-1:0] BYTE_NO = ADDR_W'(b);
      logic [7:0] byte_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            byte_q <= INIT_MASK[b*8 +: 8];
         else if (set_en && set_byte == BYTE_NO)
            byte_q <= byte_q | (8'd1 << set_bit);
      end

      assign map_flat[b*8 +: 8] = byte_q;
   end
endmodule

// File: rtl/cpm_rd_port.sv
`timescale 1ns/1ps
module cpm_rd_port #(
   parameter int  MAP_BYTES = 32,
   parameter int  BUS_BYTES = 4,
   localparam int ADDR_W    = $clog2(MAP_BYTES),
   localparam int SZ_W      = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1,
   localparam int OFF_W     = ADDR_W + SZ_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [SZ_W-1:0]        size,
   input  logic                   legacy_mode,
   input  logic [MAP_BYTES*8-1:0] map_flat,
   output logic [BUS_BYTES*8-1:0] rd_data,
   output logic                   rd_valid
);
   logic [BUS_BYTES*8-1:0] lane_d;

   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      localparam logic [SZ_W-1:0]  LANE_NO  = SZ_W'(k);
      localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(k);
      logic [OFF_W-1:0] off;

      assign off = OFF_W'(addr) + LANE_OFF;

      always_comb begin
         lane_d[k*8 +: 8] = 8'h00;
         if (legacy_mode && LANE_NO <= size && off < OFF_W'(MAP_BYTES))
            lane_d[k*8 +: 8] = map_flat[{off[ADDR_W-1:0], 3'b000} +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= lane_d;
      end
   end
endmodule

// File: rtl/cpu_presence_map.sv
`timescale 1ns/1ps
module cpu_presence_map
   import cpm_pkg::*;
#(
   parameter int                     MAP_BYTES = 32,
   parameter int                     BUS_BYTES = 4,
   parameter int                     PLUG_ID_W = 10,
   parameter logic [MAP_BYTES*8-1:0] INIT_MASK = {{(MAP_BYTES*8-4){1'b0}}, 4'hF},
   localparam int                    IDX_W     = $clog2(MAP_BYTES*8),
   localparam int                    ADDR_W    = $clog2(MAP_BYTES),
   localparam int                    SZ_W      = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_en,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [SZ_W-1:0]        size,
   input  logic [BUS_BYTES*8-1:0] wr_data,
   output logic [BUS_BYTES*8-1:0] rd_data,
   output logic                   rd_valid,
   input  logic                   plug_valid,
   input  logic [PLUG_ID_W-1:0]   plug_id,
   output logic                   gpe_pulse,
   output logic                   fwd_valid,
   output logic [PLUG_ID_W-1:0]   fwd_id,
   output logic                   legacy_mode
);
   if (MAP_BYTES < 1 || (MAP_BYTES & (MAP_BYTES - 1)) != 0) begin : g_chk_map
      $error("MAP_BYTES must be a power of two");
   end
   if (BUS_BYTES < 1 || BUS_BYTES > 8) begin : g_chk_bus
      $error("BUS_BYTES must lie in 1..8");
   end
   if (PLUG_ID_W < IDX_W) begin : g_chk_id
      $error("PLUG_ID_W too narrow for the map");
   end

   plug_route_e            route;
   logic                   switch_req;
   logic [MAP_BYTES*8-1:0] map_flat;
   logic                   unused_wr;

   assign switch_req = wr_en && (addr == '0) && (wr_data[7:0] == 8'h00);
   assign unused_wr  = ^wr_data;

   cpm_mode_ctl #(.PLUG_ID_W(PLUG_ID_W), .IDX_W(IDX_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .plug_valid(plug_valid), .plug_id(plug_id),
      .switch_req(switch_req), .legacy_mode(legacy_mode), .route(route),
      .gpe_pulse(gpe_pulse), .fwd_valid(fwd_valid), .fwd_id(fwd_id)
   );

   cpm_bitmap #(.MAP_BYTES(MAP_BYTES), .INIT_MASK(INIT_MASK)) u_map (
      .clk(clk), .rst_n(rst_n), .set_en(route == PLUG_SET),
      .set_idx(plug_id[IDX_W-1:0]), .map_flat(map_flat)
   );

   cpm_rd_port #(.MAP_BYTES(MAP_BYTES), .BUS_BYTES(BUS_BYTES)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .size(size),
      .legacy_mode(legacy_mode), .map_flat(map_flat),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );
endmodule

// File: rtl/cpm_checker.sv
`timescale 1ns/1ps
module cpm_checker #(
   parameter int BUS_BYTES = 4,
   parameter int PLUG_ID_W = 10,
   parameter int ADDR_W    = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic [ADDR_W-1:0]      addr,
   input logic [BUS_BYTES*8-1:0] wr_data,
   input logic [BUS_BYTES*8-1:0] rd_data,
   input logic                   rd_valid,
   input logic                   plug_valid,
   input logic                   gpe_pulse,
   input logic                   fwd_valid,
   input logic                   legacy_mode
);
   // R3: an event only follows a plug request made while in legacy mode
   assert_gpe_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gpe_pulse |-> ($past(plug_valid) && $past(legacy_mode)));

   // R6: one request never yields both an event and a forward
   assert_excl_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(gpe_pulse && fwd_valid));

   // R7: a forward always comes from a plug request
   assert_fwd_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> $past(plug_valid));

   // R7: read data issued outside legacy mode is zero
   assert_zero_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !$past(legacy_mode)) |-> (rd_data == '0));

   // R5: a zero lane-0 write at offset 0 ends legacy mode
   assert_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0 && wr_data[7:0] == 8'h00) |=> !legacy_mode);

   // R8: legacy mode never comes back without reset
   assert_no_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_mode |=> !legacy_mode);
endmodule

bind cpu_presence_map cpm_checker #(
   .BUS_BYTES(BUS_BYTES), .PLUG_ID_W(PLUG_ID_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .rd_data(rd_data), .rd_valid(rd_valid), .plug_valid(plug_valid),
   .gpe_pulse(gpe_pulse), .fwd_valid(fwd_valid), .legacy_mode(legacy_mode)
);

// File: tb/cpu_presence_map_tb.sv
`timescale 1ns/1ps
module cpu_presence_map_tb;
   localparam logic [255:0] INIT = (256'd1 << 255) | 256'h0F0F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0, plug_valid = 1'b0;
   logic [4:0]  addr = '0;
   logic [1:0]  size = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        rd_valid, gpe_pulse, fwd_valid, legacy_mode;
   logic [9:0]  plug_id = '0;
   logic [9:0]  fwd_id;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [255:0] model;
   bit           legacy_m;
   logic [31:0]  exp_q[$];
   string        req_q[$];

   always #5 clk = ~clk;

   cpu_presence_map #(.INIT_MASK(INIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .size(size), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
      .plug_valid(plug_valid), .plug_id(plug_id), .gpe_pulse(gpe_pulse),
      .fwd_valid(fwd_valid), .fwd_id(fwd_id), .legacy_mode(legacy_mode)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pop the expected read data when the design presents it
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check("R2 unexpected rd_valid", 32'd1, 32'd0);
         end else begin
            logic [31:0] e;
            string       r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(r, rd_data, e);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model = INIT;
      legacy_m = 1'b1;
   endtask

   task automatic do_read(input logic [4:0] a, input logic [1:0] s, input string req);
      logic [31:0] e;
      e = '0;
      for (int k = 0; k < 4; k++) begin
         int off;
         off = int'(a) + k;
         if (legacy_m && k <= int'(s) && off < 32) e[k*8 +: 8] = model[off*8 +: 8];
      end
      exp_q.push_back(e);
      req_q.push_back(req);
      rd_en = 1'b1; addr = a; size = s;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_write(input logic [4:0] a, input logic [1:0] s, input logic [31:0] d);
      wr_en = 1'b1; addr = a; size = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == 0 && d[7:0] == 8'h00) legacy_m = 1'b0;
   endtask

   task automatic do_plug(input logic [9:0] id, input string req);
      bit set_it;
      set_it = legacy_m && id < 10'd256;
      plug_valid = 1'b1; plug_id = id;
      @(negedge clk);
      plug_valid = 1'b0;
      check({req, " gpe_pulse"}, {31'd0, gpe_pulse}, {31'd0, set_it});
      check({req, " fwd_valid"}, {31'd0, fwd_valid}, {31'd0, !set_it});
      if (!set_it) check({req, " fwd_id"}, {22'd0, fwd_id}, {22'd0, id});
      if (set_it) model[id[7:0]] = 1'b1;
      if (id >= 10'd256) legacy_m = 1'b0;
      check({req, " legacy_mode"}, {31'd0, legacy_mode}, {31'd0, legacy_m});
      @(negedge clk);
      check({req, " one-cycle pulse"}, {30'd0, gpe_pulse, fwd_valid}, 32'd0);
   endtask

   initial begin
      do_reset();
      // R1: reset state
      check("R1 legacy_mode", {31'd0, legacy_mode}, 32'd1);
      check("R1 gpe_pulse", {31'd0, gpe_pulse}, 32'd0);
      check("R1 fwd_valid", {31'd0, fwd_valid}, 32'd0);
      do_read(5'd0, 2'd3, "R1 preload bytes 0..3");
      do_read(5'd31, 2'd0, "R1 preload byte 31");
      // R2: lane masking by size and by window end
      do_read(5'd30, 2'd3, "R2 lanes past offset 31");
      do_read(5'd1, 2'd1, "R2 two-byte read");
      do_read(5'd0, 2'd2, "R2 three-byte read");
      // R3: plug requests
      do_plug(10'd20, "R3 new id 20");
      do_plug(10'd0, "R3 preset id 0");
      do_plug(10'd255, "R3 top id 255");
      do_plug(10'd100, "R3 new id 100");
      do_read(5'd0, 2'd3, "R3 readback bytes 0..3");
      do_read(5'd12, 2'd0, "R3 readback byte 12");
      // R4 and R5: writes that change nothing
      do_write(5'd2, 2'd0, 32'h0000_00FF);
      do_write(5'd0, 2'd0, 32'h0000_0055);
      do_write(5'd1, 2'd0, 32'h0000_0000);
      do_write(5'd0, 2'd3, 32'h0000_0012);
      check("R5 legacy kept after non-switching writes", {31'd0, legacy_mode}, 32'd1);
      do_read(5'd0, 2'd3, "R4 map unchanged by writes");
      // R6: out-of-range plug
      do_plug(10'd256, "R6 id 256");
      do_read(5'd0, 2'd3, "R7 read after switch");
      do_plug(10'd3, "R7 forward id 3");
      do_plug(10'd1023, "R7 forward id 1023");
      do_write(5'd0, 2'd0, 32'h0000_0077);
      check("R8 legacy stays 0", {31'd0, legacy_mode}, 32'd0);
      // R5: the true switch write
      do_reset();
      check("R1 legacy after second reset", {31'd0, legacy_mode}, 32'd1);
      do_read(5'd0, 2'd3, "R1 map restored by reset");
      do_write(5'd0, 2'd3, 32'hFFFF_FF00);
      check("R5 switch by zero lane 0", {31'd0, legacy_mode}, 32'd0);
      do_read(5'd31, 2'd0, "R7 read zero in modern mode");
      do_plug(10'd9, "R7 forward after write switch");
      repeat (3) @(negedge clk);
      check("R2 all reads answered", exp_q.size(), 32'd0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule